// File: doc/BRIEF.md
# Decrement-and-Branch Loop Unit

This block is the execute-stage unit for a loop instruction that tests a condition, decrements a counter and branches. A one-cycle start strobe presents a 4-bit condition selector, the four arithmetic flags (negative, zero, overflow, carry), the 32-bit value of the counter register, that register's 3-bit index, the address of the instruction and a signed 16-bit displacement. Exactly one cycle later the unit raises a one-cycle done pulse. With that pulse it gives the new counter value, a write strobe for the register file, a branch-taken flag and the address of the next instruction.

When the selected condition is true, the loop exits. The register is left alone and execution falls through. When the condition is false, only the low 16 bits of the counter are decremented. The loop branches back unless the new 16-bit count has reached -1. The flags are never modified, and the unit has no flag output.

Top module: `dec_loop_unit`

## Requirements
- R1: Each start strobe is answered by done high on the following cycle only, and done is low in every cycle that does not follow a start.
- R2: When the condition is true, the registered value equals the input register value, the write strobe stays low and taken is 0.
- R3: When the condition is false, the low 16 bits of the result equal the input low 16 bits minus one, modulo 2^16. The upper 16 bits are copied unchanged, so no borrow reaches them even from a low half of 0x0000. The write strobe is high during the done pulse.
- R4: After a decrement, taken is 1 exactly when the new low 16 bits differ from 0xFFFF.
- R5: When taken, the next address is the instruction address plus 2 plus the sign-extended displacement, modulo 2^32.
- R6: When not taken, the next address is the instruction address plus 4, modulo 2^32.
- R7: The selector values 0 to 15 decode as follows:
  - 0 always true; 1 always false.
  - 2: !C && !Z; 3: C || Z.
  - 4: !C; 5: C.
  - 6: !Z; 7: Z.
  - 8: !V; 9: V.
  - 10: !N; 11: N.
  - 12: N == V; 13: N != V.
  - 14: !Z && (N == V); 15: Z || (N != V).
- R8: The write index output carries the register index that was given with the start.
- R9: After reset, done, the write strobe, taken, the result, the write index and the next address are all zero.
- R10: Between done pulses, the result, write index, taken and next address hold their last values, and the write strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start strobe, one cycle per instruction |
| condSel | input | 4 | Condition selector |
| flagN | input | 1 | Negative flag |
| flagZ | input | 1 | Zero flag |
| flagV | input | 1 | Overflow flag |
| flagC | input | 1 | Carry flag |
| cntIdx | input | 3 | Index of the counter data register |
| regIn | input | 32 | Current counter register value |
| instAddr | input | 32 | Address of the loop instruction |
| disp | input | 16 | Signed branch displacement |
| done | output | 1 | One-cycle completion pulse |
| regWe | output | 1 | Register write strobe, only during done |
| wrIdx | output | 3 | Register index for the write |
| regOut | output | 32 | Value to write back |
| taken | output | 1 | Branch taken |
| nextPc | output | 32 | Next instruction address |

## Verification
The hardest case to reach is the loop's final pass. For it, the condition must be false, the low half must be exactly 0x0000, and the upper half must be non-zero, so that a borrow into the upper bits would be visible. The stimulus reaches this case directly. It picks the always-false selector with a counter of 0xABCD0000 and checks that the result is 0xABCDFFFF with no branch. It also walks all 16 selectors across all 16 flag combinations, and it covers displacements that wrap the address space in both directions.

// File: rtl/dlu_pkg.sv
package dlu_pkg;
  typedef enum logic [3:0] {
    CC_T  = 4'd0,  CC_F  = 4'd1,  CC_HI = 4'd2,  CC_LS = 4'd3,
    CC_CC = 4'd4,  CC_CS = 4'd5,  CC_NE = 4'd6,  CC_EQ = 4'd7,
    CC_VC = 4'd8,  CC_VS = 4'd9,  CC_PL = 4'd10, CC_MI = 4'd11,
    CC_GE = 4'd12, CC_LT = 4'd13, CC_GT = 4'd14, CC_LE = 4'd15
  } condSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;   // capture the computed results
    logic fire;   // result pulse cycle
  } ctlStrb_t;
endpackage

// File: rtl/dlu_cond_eval.sv
module dlu_cond_eval
  import dlu_pkg::*;
(
  input  logic [3:0] condSel,
  input  logic       flagN,
  input  logic       flagZ,
  input  logic       flagV,
  input  logic       flagC,
  output logic       condTrue
);
  logic signMatch;
  assign signMatch = (flagN == flagV);

  always_comb begin
    unique case (condSel_e'(condSel))
      CC_T:    condTrue = 1'b1;
      CC_F:    condTrue = 1'b0;
      CC_HI:   condTrue = !flagC && !flagZ;
      CC_LS:   condTrue = flagC || flagZ;
      CC_CC:   condTrue = !flagC;
      CC_CS:   condTrue = flagC;
      CC_NE:   condTrue = !flagZ;
      CC_EQ:   condTrue = flagZ;
      CC_VC:   condTrue = !flagV;
      CC_VS:   condTrue = flagV;
      CC_PL:   condTrue = !flagN;
      CC_MI:   condTrue = flagN;
      CC_GE:   condTrue = signMatch;
      CC_LT:   condTrue = !signMatch;
      CC_GT:   condTrue = !flagZ && signMatch;
      default: condTrue = flagZ || !signMatch;
    endcase
  end
endmodule

// File: rtl/dlu_control.sv
module dlu_control
  import dlu_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  output ctlStrb_t strb,
  output logic     done
);
  logic doneQ;

  always_ff @(posedge clk) begin
    if (!rstN) doneQ <= 1'b0;
    else       doneQ <= start;
  end

  assign strb.load = start;
  assign strb.fire = doneQ;
  assign done      = doneQ;
endmodule

// File: rtl/dlu_datapath.sv
module dlu_datapath
  import dlu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 32,
  parameter int DISP_W = 16,
  parameter int IDX_W  = 3,
  parameter int INST_BYTES = 2,
  parameter int EXT_BYTES  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrb_t          strb,
  input  logic              condTrue,
  input  logic [IDX_W-1:0]  cntIdx,
  input  logic [DATA_W-1:0] regIn,
  input  logic [ADDR_W-1:0] instAddr,
  input  logic [DISP_W-1:0] disp,
  output logic              regWe,
  output logic [IDX_W-1:0]  wrIdx,
  output logic [DATA_W-1:0] regOut,
  output logic              taken,
  output logic [ADDR_W-1:0] nextPc
);
  localparam int UP_W = DATA_W - CNT_W;
  localparam logic [CNT_W-1:0]  CNT_END  = '1;
  localparam logic [ADDR_W-1:0] BR_BASE  = ADDR_W'(INST_BYTES);
  localparam logic [ADDR_W-1:0] FALL_OFS = ADDR_W'(INST_BYTES + EXT_BYTES);

  logic [CNT_W-1:0]  cntDec;
  logic [DATA_W-1:0] decWord;
  logic [ADDR_W-1:0] dispExt;
  logic              branchNow;
  logic              weQ;

  assign cntDec = regIn[CNT_W-1:0] - CNT_W'(1);

  generate
    if (UP_W > 0) begin : g_upper
      assign decWord = {regIn[DATA_W-1:CNT_W], cntDec};
    end else begin : g_flat
      assign decWord = cntDec;
    end
  endgenerate

  assign dispExt   = {{(ADDR_W-DISP_W){disp[DISP_W-1]}}, disp};
  assign branchNow = !condTrue && (cntDec != CNT_END);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regOut <= '0;
      weQ    <= 1'b0;
      taken  <= 1'b0;
      nextPc <= '0;
      wrIdx  <= '0;
    end else if (strb.load) begin
      regOut <= condTrue ? regIn : decWord;
      weQ    <= !condTrue;
      taken  <= branchNow;
      nextPc <= branchNow ? instAddr + BR_BASE + dispExt : instAddr + FALL_OFS;
      wrIdx  <= cntIdx;
    end
  end

  assign regWe = weQ && strb.fire;
endmodule

// File: rtl/dec_loop_unit.sv
module dec_loop_unit
  import dlu_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [3:0]  condSel,
  input  logic        flagN,
  input  logic        flagZ,
  input  logic        flagV,
  input  logic        flagC,
  input  logic [2:0]  cntIdx,
  input  logic [31:0] regIn,
  input  logic [31:0] instAddr,
  input  logic [15:0] disp,
  output logic        done,
  output logic        regWe,
  output logic [2:0]  wrIdx,
  output logic [31:0] regOut,
  output logic        taken,
  output logic [31:0] nextPc
);
  ctlStrb_t strb;
  logic     condTrue;

  dlu_cond_eval u_cond (
    .condSel(condSel), .flagN(flagN), .flagZ(flagZ), .flagV(flagV),
    .flagC(flagC), .condTrue(condTrue)
  );

  dlu_control u_ctl (
    .clk(clk), .rstN(rstN), .start(start), .strb(strb), .done(done)
  );

  dlu_datapath #(
    .DATA_W(32), .CNT_W(16), .ADDR_W(32), .DISP_W(16), .IDX_W(3)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .condTrue(condTrue),
    .cntIdx(cntIdx), .regIn(regIn), .instAddr(instAddr), .disp(disp),
    .regWe(regWe), .wrIdx(wrIdx), .regOut(regOut), .taken(taken),
    .nextPc(nextPc)
  );
endmodule

// File: rtl/dec_loop_unit_chk.sv
module dec_loop_unit_chk (
  input logic        clk,
  input logic        rstN,
  input logic        start,
  input logic [2:0]  cntIdx,
  input logic [31:0] regIn,
  input logic [31:0] instAddr,
  input logic [15:0] disp,
  input logic        done,
  input logic        regWe,
  input logic [2:0]  wrIdx,
  input logic [31:0] regOut,
  input logic        taken,
  input logic [31:0] nextPc
);
  assert_done_follows_R1: assert property (@(posedge clk) disable iff (!rstN)
    start |=> done);
  assert_done_only_after_start_R1: assert property (@(posedge clk) disable iff (!rstN)
    !start |=> !done);
  assert_exit_keeps_reg_R2: assert property (@(posedge clk) disable iff (!rstN)
    (done && !regWe) |-> (regOut == $past(regIn) && !taken));
  assert_low_decrement_R3: assert property (@(posedge clk) disable iff (!rstN)
    (done && regWe) |-> (regOut[15:0] == $past(regIn[15:0]) - 16'd1
                         && regOut[31:16] == $past(regIn[31:16])));
  assert_taken_not_end_R4: assert property (@(posedge clk) disable iff (!rstN)
    (done && taken) |-> (regWe && regOut[15:0] != 16'hFFFF));
  assert_target_R5: assert property (@(posedge clk) disable iff (!rstN)
    (done && taken) |-> nextPc == $past(instAddr) + 32'd2
                                  + {{16{$past(disp[15])}}, $past(disp)});
  assert_fall_through_R6: assert property (@(posedge clk) disable iff (!rstN)
    (done && !taken) |-> nextPc == $past(instAddr) + 32'd4);
  assert_index_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> wrIdx == $past(cntIdx));
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !start |=> ($stable(regOut) && $stable(nextPc) && $stable(taken) && $stable(wrIdx)));
  assert_we_in_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    regWe |-> done);
endmodule

bind dec_loop_unit dec_loop_unit_chk u_chk (.*);

// File: tb/dec_loop_unit_tb.sv
`timescale 1ns/1ps
module dec_loop_unit_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  condSel = '0;
  logic        flagN = 1'b0, flagZ = 1'b0, flagV = 1'b0, flagC = 1'b0;
  logic [2:0]  cntIdx = '0;
  logic [31:0] regIn = '0, instAddr = '0;
  logic [15:0] disp = '0;
  logic        done, regWe, taken;
  logic [2:0]  wrIdx;
  logic [31:0] regOut, nextPc;

  always #2.5 clk = ~clk;

  dec_loop_unit u_dut (.*);

  typedef struct {
    logic [31:0] val;
    logic        we;
    logic        tk;
    logic [31:0] pc;
    logic [2:0]  idx;
  } exp_t;

  exp_t expQ[$];
  exp_t lastExp;
  bit   haveLast = 0;
  bit   running = 0;
  int   total = 0;
  int   bad = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // R7 condition table, written from the requirement
  function automatic bit condOf(input logic [3:0] s, input bit n, input bit z,
                                input bit v, input bit c);
    case (s)
      4'd0:  return 1;
      4'd1:  return 0;
      4'd2:  return !c && !z;
      4'd3:  return c || z;
      4'd4:  return !c;
      4'd5:  return c;
      4'd6:  return !z;
      4'd7:  return z;
      4'd8:  return !v;
      4'd9:  return v;
      4'd10: return !n;
      4'd11: return n;
      4'd12: return n == v;
      4'd13: return n != v;
      4'd14: return !z && (n == v);
      default: return z || (n != v);
    endcase
  endfunction

  task automatic drive(input logic [3:0] s, input logic [3:0] f,
                       input logic [2:0] idx, input logic [31:0] r,
                       input logic [31:0] pc, input logic [15:0] d);
    exp_t e;
    bit   ct;
    logic [15:0] lo;
    @(negedge clk);
    condSel = s; {flagN, flagZ, flagV, flagC} = f;
    cntIdx = idx; regIn = r; instAddr = pc; disp = d; start = 1'b1;
    ct = condOf(s, f[3], f[2], f[1], f[0]);
    lo = r[15:0] - 16'd1;
    e.idx = idx;
    if (ct) begin
      e.val = r; e.we = 0; e.tk = 0;                       // R2
    end else begin
      e.val = {r[31:16], lo}; e.we = 1; e.tk = (lo != 16'hFFFF); // R3 R4
    end
    e.pc = e.tk ? pc + 32'd2 + {{16{d[15]}}, d} : pc + 32'd4; // R5 R6
    expQ.push_back(e);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    start = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // monitor
  always @(negedge clk) begin
    if (running) begin
      if (done) begin
        if (expQ.size() == 0) begin
          check(0, "R1", "done without start", 32'd1, 32'd0);
        end else begin
          exp_t e;
          e = expQ.pop_front();
          check(regOut === e.val, "R2_R3", "regOut", regOut, e.val);
          check(regWe === e.we, "R3", "regWe", {31'd0, regWe}, {31'd0, e.we});
          check(taken === e.tk, "R4", "taken", {31'd0, taken}, {31'd0, e.tk});
          check(nextPc === e.pc, "R5_R6", "nextPc", nextPc, e.pc);
          check(wrIdx === e.idx, "R8", "wrIdx", {29'd0, wrIdx}, {29'd0, e.idx});
          lastExp = e; haveLast = 1;
        end
      end else if (haveLast) begin
        check(regOut === lastExp.val && nextPc === lastExp.pc &&
              taken === lastExp.tk && wrIdx === lastExp.idx && regWe === 1'b0,
              "R10", "hold regOut", regOut, lastExp.val);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check(done === 0 && regWe === 0 && taken === 0, "R9", "ctl outs",
          {29'd0, done, regWe, taken}, 32'd0);
    check(regOut === 0 && nextPc === 0 && wrIdx === 0, "R9", "data outs",
          regOut ^ nextPc, 32'd0);
    rstN = 1'b1;
    running = 1;
    // R7: every selector against every flag combination, back to back
    for (int s = 0; s < 16; s++)
      for (int f = 0; f < 16; f++)
        drive(4'(s), 4'(f), 3'(s), 32'h1234_0005 + 32'(f), 32'h0000_1000, 16'h0010);
    idle(3);
    // R3/R4 boundary: low half 0 wraps to FFFF, no borrow, no branch
    drive(4'd1, 4'h0, 3'd2, 32'hABCD_0000, 32'h0000_2000, 16'hFFF0);
    idle(2);
    // R4: low half 1 -> 0, still branches
    drive(4'd1, 4'h0, 3'd7, 32'h0000_0001, 32'h0000_2000, 16'hFFF0);
    // R5: negative displacement wraps below zero
    drive(4'd1, 4'h0, 3'd3, 32'h0000_0010, 32'h0000_0000, 16'hFFFC);
    // R5: positive displacement wraps above top
    drive(4'd1, 4'h0, 3'd4, 32'hFFFF_FFFF, 32'hFFFF_FFF0, 16'h7FFF);
    // R6: fall-through wraps at top
    drive(4'd0, 4'h0, 3'd5, 32'h5555_AAAA, 32'hFFFF_FFFE, 16'h0100);
    // R2: condition true with counter already at 0
    drive(4'd7, 4'h4, 3'd6, 32'hFFFF_0000, 32'h0000_3000, 16'h0002);
    idle(4);
    if (expQ.size() != 0) check(0, "R1", "missing done", 32'(expQ.size()), 32'd0);
    running = 0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    check(0, "R1", "watchdog", 32'd1, 32'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule